// File: doc/BRIEF.md
# Chained Instruction Chunk Fetcher

This block reads fixed-size instructions for a single command queue out of memory. Instructions live in segments that are linked into a list. Software writes a start address and a segment size. It then rings a doorbell with word counts. While the queue is enabled and enough credit is pending, the fetcher reads one 64-bit word at a time through a single-outstanding request/response memory port. It presents each word on a valid/ready output stream and flags the eighth word of every instruction.

A segment of `8n+1` words holds `n` instructions followed by one link word. After the `n`th instruction of a segment, the fetcher reads that link word without waiting for credit. It takes address bits 48:6 of the link word as the new current address and carries on from there. An optional byte reversal is applied to every word read, both instruction words and link words. A read error stops the fetcher until software rewrites the pointer.

Top module: `instr_chunk_fetch`

## Requirements
- R1: After reset, `out_valid`, `mem_req_valid` and `rd_err` are low, and both `db_count` and `ptr_rdata` read zero.
- R2: A pointer write keeps bits 48:6 of `ptr_wdata`. `ptr_rdata` always reads bits 5:0 as zero.
- R3: A `db_add` pulse adds `db_words` to `db_count`. Starting an instruction needs `db_count >= 8` and subtracts 8 from it. A start and an add in the same cycle are both applied.
- R4: While `q_en` is low, no new instruction or link read is started, even when credit is pending.
- R5: Word k (0..7) of an instruction is requested at address `ptr_rdata + 8*k`, in ascending order. The eight words leave on the stream in that order, and `out_last` is high only on word 7.
- R6: `ptr_rdata` advances by 64 once word 7 of an instruction has been accepted on the output.
- R7: With `seg_words = 8n+1`, after n instructions from the start of a segment the next read is to `ptr_rdata` itself. Bits 48:6 of the returned word become the new pointer. No output word is produced for that read, and it consumes no credit.
- R8: When `big_endian` is 1, each returned word is byte-reversed (byte 0 becomes byte 7) before use, for both instruction words and link words.
- R9: A response with `mem_rsp_err` set produces no output word and a one-cycle `rd_err` pulse in the cycle after the response. No further request is made until the pointer is rewritten, and that rewrite resumes fetching.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R11: A pointer write is honoured only when no instruction or link read is in progress. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en | input | 1 | Queue enable; gates the start of each fetch |
| big_endian | input | 1 | Byte-reverse every word read from memory |
| seg_words | input | 13 | Segment size in 64-bit words (8n+1) |
| ptr_wr | input | 1 | Write strobe for the start pointer |
| ptr_wdata | input | 49 | Start byte address; bits 5:0 are dropped |
| ptr_rdata | output | 49 | Current read address (next instruction or link word) |
| db_add | input | 1 | Doorbell strobe |
| db_words | input | 20 | Word count added on a doorbell |
| db_count | output | 20 | Pending doorbell words |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 49 | Byte address of the requested 64-bit word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| out_valid | output | 1 | Instruction word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 64 | Instruction word |
| out_last | output | 1 | Eighth word of an instruction |
| rd_err | output | 1 | One-cycle read-error pulse |

## Verification
Doorbell accumulation and credit consumption can land in the same clock edge. The bench sets this up by holding the queue disabled with exactly one instruction's worth of credit pending. In one cycle it then raises the enable together with a doorbell of 16 words. The idle fetcher starts an instruction on that edge while the add is applied, so the count must read 8 + 16 - 8 = 24 - 8 = 16 one cycle later, with a read request already on the port. A second overlap is a pointer write arriving while a fetched word is held by backpressure; it must leave the pointer and the held word untouched.

// File: rtl/chunk_fetch_pkg.sv
package chunk_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RQ_INST = 3'd1,
    ST_WT_INST = 3'd2,
    ST_PUSH    = 3'd3,
    ST_RQ_LINK = 3'd4,
    ST_WT_LINK = 3'd5,
    ST_HALT    = 3'd6
  } fetch_st_e;

endpackage

// File: rtl/chunk_fetch_bswap.sv
module chunk_fetch_bswap #(
  parameter int DW = 64
) (
  input  logic          swap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  logic [DW-1:0] swapped;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign swapped[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
  end

  assign dout = swap_en ? swapped : din;

endmodule

// File: rtl/chunk_fetch_credit.sv
module chunk_fetch_credit #(
  parameter int CNT_W      = 20,
  parameter int INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             enough
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(INST_WORDS);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_ce;

  always_comb begin
    count_d = count_q;
    if (add_en) count_d = count_d + add_val;
    if (take)   count_d = count_d - STEP;
  end

  assign count_ce = add_en | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_d;
  end

  assign count  = count_q;
  assign enough = (count_q >= STEP);

  assert_credit_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !add_en) |=> (count == $past(count) - STEP));

  assert_credit_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !take) |=> (count == $past(count) + $past(add_val)));

  assert_take_needs_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> enough);

endmodule

// File: rtl/chunk_fetch_cursor.sv
module chunk_fetch_cursor #(
  parameter int AW         = 49,
  parameter int DW         = 64,
  parameter int SEG_W      = 13,
  parameter int INST_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SEG_W-1:0] seg_words,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          link_load,
  input  logic [DW-1:0] link_word,
  input  logic          word_adv,
  input  logic          inst_done,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] inst_addr,
  output logic          widx_last,
  output logic          seg_end
);
  localparam int WB     = $clog2(DW / 8);
  localparam int WIDX_W = $clog2(INST_WORDS);
  localparam int OFF_W  = WIDX_W + WB;
  localparam int PTR_W  = AW - OFF_W;
  localparam int ICNT_W = SEG_W - WIDX_W;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [ICNT_W-1:0] icnt_q, icnt_d;
  logic              cur_ce;
  logic [ICNT_W-1:0] seg_insts;
  logic              unused_bits;

  assign seg_insts   = seg_words[SEG_W-1:WIDX_W];
  assign unused_bits = ^{load_addr[OFF_W-1:0], link_word[DW-1:AW], link_word[OFF_W-1:0],
                         seg_words[WIDX_W-1:0]};

  always_comb begin
    ptr_d  = ptr_q;
    widx_d = widx_q;
    icnt_d = icnt_q;
    if (load) begin
      ptr_d  = load_addr[AW-1:OFF_W];
      widx_d = '0;
      icnt_d = '0;
    end else if (link_load) begin
      ptr_d  = link_word[AW-1:OFF_W];
      widx_d = '0;
      icnt_d = '0;
    end else if (inst_done) begin
      ptr_d  = ptr_q + 1'b1;
      widx_d = '0;
      icnt_d = icnt_q + 1'b1;
    end else if (word_adv) begin
      widx_d = widx_q + 1'b1;
    end
  end

  assign cur_ce = load | link_load | inst_done | word_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      widx_q <= '0;
      icnt_q <= '0;
    end else if (cur_ce) begin
      ptr_q  <= ptr_d;
      widx_q <= widx_d;
      icnt_q <= icnt_d;
    end
  end

  assign cur_addr  = {ptr_q, {OFF_W{1'b0}}};
  assign inst_addr = {ptr_q, widx_q, {WB{1'b0}}};
  assign widx_last = (widx_q == WIDX_W'(INST_WORDS - 1));
  assign seg_end   = (icnt_q == seg_insts);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && !load) |=> (cur_addr == $past(cur_addr) + AW'(1 << OFF_W)));

  assert_word_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_adv && !load) |=> (inst_addr == $past(inst_addr) + AW'(1 << WB)));

endmodule

// File: rtl/chunk_fetch_ctrl.sv
module chunk_fetch_ctrl
  import chunk_fetch_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          ptr_wr,
  input  logic          enough,
  input  logic          seg_end,
  input  logic          widx_last,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic [DW-1:0] rsp_word,
  input  logic          out_ready,
  output logic          take,
  output logic          load_ok,
  output logic          req_valid,
  output logic          req_link,
  output logic          word_adv,
  output logic          inst_done,
  output logic          link_load,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          rd_err
);
  fetch_st_e     st_q, st_d;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          cap;
  logic          err_d, err_q;

  always_comb begin
    st_d      = st_q;
    take      = 1'b0;
    load_ok   = 1'b0;
    req_valid = 1'b0;
    req_link  = 1'b0;
    word_adv  = 1'b0;
    inst_done = 1'b0;
    link_load = 1'b0;
    cap       = 1'b0;
    err_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ptr_wr) begin
          load_ok = 1'b1;
        end else if (q_en) begin
          if (seg_end) begin
            st_d = ST_RQ_LINK;
          end else if (enough) begin
            take = 1'b1;
            st_d = ST_RQ_INST;
          end
        end
      end
      ST_RQ_INST: begin
        req_valid = 1'b1;
        if (req_ready) st_d = ST_WT_INST;
      end
      ST_WT_INST: begin
        if (rsp_valid) begin
          if (rsp_err) begin
            err_d = 1'b1;
            st_d  = ST_HALT;
          end else begin
            cap  = 1'b1;
            st_d = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        if (out_ready) begin
          if (widx_last) begin
            inst_done = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            word_adv = 1'b1;
            st_d     = ST_RQ_INST;
          end
        end
      end
      ST_RQ_LINK: begin
        req_valid = 1'b1;
        req_link  = 1'b1;
        if (req_ready) st_d = ST_WT_LINK;
      end
      ST_WT_LINK: begin
        if (rsp_valid) begin
          if (rsp_err) begin
            err_d = 1'b1;
            st_d  = ST_HALT;
          end else begin
            link_load = 1'b1;
            st_d      = ST_IDLE;
          end
        end
      end
      ST_HALT: begin
        if (ptr_wr) begin
          load_ok = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      last_q <= 1'b0;
    end else if (cap) begin
      data_q <= rsp_word;
      last_q <= widx_last;
    end
  end

  assign out_valid = (st_q == ST_PUSH);
  assign out_data  = data_q;
  assign out_last  = last_q;
  assign rd_err    = err_q;

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_link)));

  assert_no_issue_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !q_en) |=> !req_valid);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> (!req_valid && !rd_err));

  assert_err_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |=> !out_valid);

endmodule

// File: rtl/instr_chunk_fetch.sv
module instr_chunk_fetch #(
  parameter int AW         = 49,
  parameter int DW         = 64,
  parameter int SEG_W      = 13,
  parameter int CNT_W      = 20,
  parameter int INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_en,
  input  logic             big_endian,
  input  logic [SEG_W-1:0] seg_words,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_wdata,
  output logic [AW-1:0]    ptr_rdata,
  input  logic             db_add,
  input  logic [CNT_W-1:0] db_words,
  output logic [CNT_W-1:0] db_count,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             rd_err
);
  logic          take, enough;
  logic          load_ok, link_load, word_adv, inst_done;
  logic          req_link, widx_last, seg_end;
  logic [AW-1:0] cur_addr, inst_addr;
  logic [DW-1:0] rsp_word;

  chunk_fetch_bswap #(.DW(DW)) u_swap (
    .swap_en (big_endian),
    .din     (mem_rsp_data),
    .dout    (rsp_word)
  );

  chunk_fetch_credit #(.CNT_W(CNT_W), .INST_WORDS(INST_WORDS)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (db_add),
    .add_val (db_words),
    .take    (take),
    .count   (db_count),
    .enough  (enough)
  );

  chunk_fetch_cursor #(.AW(AW), .DW(DW), .SEG_W(SEG_W), .INST_WORDS(INST_WORDS)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_words (seg_words),
    .load      (load_ok),
    .load_addr (ptr_wdata),
    .link_load (link_load),
    .link_word (rsp_word),
    .word_adv  (word_adv),
    .inst_done (inst_done),
    .cur_addr  (cur_addr),
    .inst_addr (inst_addr),
    .widx_last (widx_last),
    .seg_end   (seg_end)
  );

  chunk_fetch_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_en      (q_en),
    .ptr_wr    (ptr_wr),
    .enough    (enough),
    .seg_end   (seg_end),
    .widx_last (widx_last),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .rsp_err   (mem_rsp_err),
    .rsp_word  (rsp_word),
    .out_ready (out_ready),
    .take      (take),
    .load_ok   (load_ok),
    .req_valid (mem_req_valid),
    .req_link  (req_link),
    .word_adv  (word_adv),
    .inst_done (inst_done),
    .link_load (link_load),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .rd_err    (rd_err)
  );

  assign mem_req_addr = req_link ? cur_addr : inst_addr;
  assign ptr_rdata    = cur_addr;

  assert_link_at_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && req_link) |-> (mem_req_addr == ptr_rdata));

  assert_ptr_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rdata[5:0] == 6'd0));

endmodule

// File: tb/instr_chunk_fetch_tb.sv
`timescale 1ns/1ps
module instr_chunk_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        q_en, big_endian, ptr_wr, db_add;
  logic [12:0] seg_words;
  logic [48:0] ptr_wdata, ptr_rdata, mem_req_addr;
  logic [19:0] db_words, db_count;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [63:0] mem_rsp_data, out_data;
  logic        out_valid, out_ready, out_last, rd_err;

  always #2.5 clk = ~clk;

  instr_chunk_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .big_endian(big_endian), .seg_words(seg_words),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
    .db_add(db_add), .db_words(db_words), .db_count(db_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .rd_err(rd_err)
  );

  int checks = 0, fails = 0;
  logic [63:0] mem [512];
  logic [48:0] alog [$];
  logic [64:0] wlog [$];
  int  errcnt = 0, cyc = 0;
  int  rmode = 0;
  logic err_on = 1'b0;
  logic [5:0] err_blk = '0;
  logic acc_pend = 1'b0;
  logic [48:0] acc_addr = '0;

  // {be, n per segment, instructions, start block, next block}
  localparam logic [21:0] VEC [4] = '{
    {1'b0, 4'd2, 5'd3, 6'd0,  6'd10},
    {1'b1, 4'd1, 5'd2, 6'd20, 6'd30},
    {1'b0, 4'd3, 5'd2, 6'd40, 6'd50},
    {1'b0, 4'd2, 5'd4, 6'd4,  6'd12}
  };

  function automatic logic [63:0] bs64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = v[(7-b)*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and consumer, all driven at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (acc_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[acc_addr[11:3]];
      mem_rsp_err   = err_on && (acc_addr[11:6] == err_blk);
      acc_pend      = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
    end
    mem_req_ready = (cyc % 4) != 3;
    if (mem_req_valid && mem_req_ready) begin
      acc_pend = 1'b1;
      acc_addr = mem_req_addr;
      alog.push_back(mem_req_addr);
    end
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    if (out_valid && out_ready) wlog.push_back({out_last, out_data});
    if (rd_err) errcnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ptr(input logic [48:0] a);
    @(negedge clk); #1 ptr_wr = 1'b1; ptr_wdata = a;
    @(negedge clk); #1 ptr_wr = 1'b0;
  endtask

  task automatic ring(input logic [19:0] w);
    @(negedge clk); #1 db_add = 1'b1; db_words = w;
    @(negedge clk); #1 db_add = 1'b0;
  endtask

  task automatic run_vec(input int vi);
    logic        be;
    int          n, cnt, blk, ic, ai;
    logic [63:0] lw, ew;
    be  = VEC[vi][21];
    n   = int'(VEC[vi][20:17]);
    cnt = int'(VEC[vi][16:12]);
    blk = int'(VEC[vi][11:6]);
    // link words carry junk outside bits 48:6
    lw = {15'h7ABC, 43'(VEC[vi][5:0]), 6'h15};
    mem[(int'(VEC[vi][11:6]) + n) * 8] = be ? bs64(lw) : lw;
    lw = {15'h1234, 43'(VEC[vi][11:6]), 6'h2A};
    mem[(int'(VEC[vi][5:0]) + n) * 8] = be ? bs64(lw) : lw;
    q_en = 1'b0; big_endian = be; seg_words = 13'(8 * n + 1);
    wr_ptr(49'(blk * 64) | 49'h2A);
    chk(ptr_rdata == 49'(blk * 64), "R2", 64'(ptr_rdata), 64'(blk * 64));
    alog.delete(); wlog.delete();
    rmode = vi % 2;
    q_en = 1'b1;
    ring(20'(cnt * 8));
    for (int t = 0; t < 4000 && wlog.size() < cnt * 8; t++) tick(1);
    tick(40);
    ic = 0; ai = 0;
    for (int k = 0; k < cnt; k++) begin
      if (ic == n) begin
        chk(alog.size() > ai && alog[ai] == 49'(blk * 64), "R7", 64'(alog[ai]), 64'(blk * 64));
        ai++;
        lw = be ? bs64(mem[blk * 8]) : mem[blk * 8];
        blk = int'(lw[11:6]); ic = 0;
      end
      for (int j = 0; j < 8; j++) begin
        chk(alog.size() > ai && alog[ai] == 49'(blk * 64 + j * 8), "R5", 64'(alog[ai]), 64'(blk * 64 + j * 8));
        ai++;
        ew = be ? bs64(mem[blk * 8 + j]) : mem[blk * 8 + j];
        chk(wlog.size() > k * 8 + j && wlog[k * 8 + j][63:0] == ew, be ? "R8" : "R5",
            wlog[k * 8 + j][63:0], ew);
        chk(wlog[k * 8 + j][64] == (j == 7), "R5", 64'(wlog[k * 8 + j][64]), 64'(j == 7));
      end
      blk++; ic++;
    end
    if (ic == n) begin
      chk(alog.size() > ai && alog[ai] == 49'(blk * 64), "R7", 64'(alog[ai]), 64'(blk * 64));
      ai++;
      lw = be ? bs64(mem[blk * 8]) : mem[blk * 8];
      blk = int'(lw[11:6]);
    end
    chk(alog.size() == ai, "R7", 64'(alog.size()), 64'(ai));
    chk(ptr_rdata == 49'(blk * 64), "R6", 64'(ptr_rdata), 64'(blk * 64));
    chk(db_count == 0, "R3", 64'(db_count), 64'd0);
    rmode = 0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = {32'hC0DE_0000 | 32'(i), 32'hFFFF_0000 ^ 32'(i * 3)};
    rst_n = 1'b0; q_en = 1'b0; big_endian = 1'b0; seg_words = '0;
    ptr_wr = 1'b0; ptr_wdata = '0; db_add = 1'b0; db_words = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    out_ready = 1'b1;
    tick(3);
    chk(!out_valid && !mem_req_valid && !rd_err, "R1", {61'd0, out_valid, mem_req_valid, rd_err}, 64'd0);
    chk(db_count == 0, "R1", 64'(db_count), 64'd0);
    chk(ptr_rdata == 0, "R1", 64'(ptr_rdata), 64'd0);
    #1 rst_n = 1'b1;
    tick(2);

    // table-driven chain walks
    for (int v = 0; v < 4; v++) run_vec(v);

    // enable gating, then enable and doorbell in the same cycle
    seg_words = 13'd33; big_endian = 1'b0; q_en = 1'b0;
    wr_ptr(49'(60 * 64));
    alog.delete(); wlog.delete();
    ring(20'd8);
    tick(20);
    chk(alog.size() == 0, "R4", 64'(alog.size()), 64'd0);
    chk(db_count == 20'd8, "R3", 64'(db_count), 64'd8);
    @(negedge clk); #1 q_en = 1'b1; db_add = 1'b1; db_words = 20'd16;
    @(negedge clk); #1 db_add = 1'b0;
    chk(db_count == 20'd16, "R3", 64'(db_count), 64'd16);
    chk(mem_req_valid || alog.size() == 1, "R3", 64'(alog.size()), 64'd1);
    tick(300);
    chk(db_count == 0, "R3", 64'(db_count), 64'd0);
    chk(wlog.size() == 24, "R3", 64'(wlog.size()), 64'd24);
    chk(ptr_rdata == 49'(63 * 64), "R6", 64'(ptr_rdata), 64'(63 * 64));

    // read error halts until pointer rewrite
    q_en = 1'b0; err_on = 1'b1; err_blk = 6'd49;
    wr_ptr(49'(48 * 64));
    alog.delete(); wlog.delete(); errcnt = 0;
    q_en = 1'b1;
    ring(20'd16);
    tick(200);
    chk(errcnt == 1, "R9", 64'(errcnt), 64'd1);
    chk(alog.size() == 9, "R9", 64'(alog.size()), 64'd9);
    chk(wlog.size() == 8, "R9", 64'(wlog.size()), 64'd8);
    chk(ptr_rdata == 49'(49 * 64), "R9", 64'(ptr_rdata), 64'(49 * 64));
    err_on = 1'b0;
    wr_ptr(49'(50 * 64));
    ring(20'd8);
    tick(200);
    chk(wlog.size() == 16 && wlog[8][63:0] == mem[400], "R9", wlog[8][63:0], mem[400]);
    chk(ptr_rdata == 49'(51 * 64), "R9", 64'(ptr_rdata), 64'(51 * 64));

    // pointer write during a held word is ignored; word held under backpressure
    q_en = 1'b0; seg_words = 13'd25;
    wr_ptr(49'(40 * 64));
    wlog.delete();
    rmode = 2; q_en = 1'b1;
    ring(20'd8);
    for (int t = 0; t < 100 && !out_valid; t++) tick(1);
    begin
      logic [63:0] held;
      held = out_data;
      wr_ptr(49'(5 * 64));
      tick(5);
      chk(out_valid && out_data == held, "R10", out_data, held);
      chk(ptr_rdata == 49'(40 * 64), "R11", 64'(ptr_rdata), 64'(40 * 64));
    end
    rmode = 0;
    tick(200);
    chk(wlog.size() == 8 && wlog[0][63:0] == mem[320], "R11", wlog[0][63:0], mem[320]);
    chk(ptr_rdata == 49'(41 * 64), "R11", 64'(ptr_rdata), 64'(41 * 64));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule